// File: doc/BRIEF.md
# Banked CPU Memory Mapper

This block translates the 16-bit logical addresses of an 8-bit CPU into a 28-bit physical address space. The logical space is cut into eight 8 KB blocks. Blocks 0 to 3 form the lower half and blocks 4 to 7 the upper half. Each half has its own 20-bit offset and its own megabyte selector. An 8-bit enable mask, one bit per block, decides whether a block is relocated or passes straight through.

The mapping state changes only when the CPU executes its map instruction. On that cycle the core raises `map_stb` and presents its four working registers. A register value of 0x0F selects the megabyte selector of a half instead of its offset and enable bits. While hypervisor mode is active, the upper-half offset and enables are protected. A map instruction also holds off interrupts until the end-of-map strobe arrives.

Translation is purely combinational from `cpu_addr` to `phys_addr`. If the mapped sum reaches or passes the top of the 28-bit space, the result is flagged as an impossible address.

Top module: `banked_mem_mapper`

## Requirements
- R1: After reset both offsets, both megabyte selectors and all eight enables are zero, `irq_inhibit` and `hyper_warn` are low, and every address passes through unmapped.
- R2: On a map strobe with `reg_x` not equal to 0x0F, the lower offset becomes `{reg_x[3:0], reg_a, 8'h00}`. The enables of blocks 0..3 become `reg_x[7:4]`, with bit 4 driving block 0, and the enables of blocks 4..7 are kept.
- R3: On a map strobe with `reg_x` equal to 0x0F, the lower megabyte selector becomes `reg_a`, which adds `reg_a << 20`. The lower offset and the lower enables are unchanged.
- R4: On a map strobe with `reg_z` not equal to 0x0F and `hyper_mode` low, the upper offset becomes `{reg_z[3:0], reg_y, 8'h00}`. The enables of blocks 4..7 become `reg_z[7:4]`, with bit 4 driving block 4, and the lower enables are kept.
- R5: On a map strobe with `reg_z` not equal to 0x0F and `hyper_mode` high, the upper offset and the upper enables do not change.
- R6: On a map strobe with `reg_z` equal to 0x0F, the upper megabyte selector becomes `reg_y`, whatever the mode. `hyper_warn` is high for exactly the one cycle after that edge, and only if `hyper_mode` was high.
- R7: A map strobe sets `irq_inhibit` from the next cycle on. It stays high until the cycle after an `eom_stb`. If both strobes fall in the same cycle, the map strobe wins.
- R8: `cpu_addr[15:13]` picks the block. If that block is enabled, `phys_addr` is the low 28 bits of (megabyte selector << 20) + half offset + `cpu_addr`, where the half is chosen by `cpu_addr[15]`.
- R9: If the selected block is disabled, `phys_addr` is `cpu_addr` zero-extended, `blk_mapped` is low and `phys_invalid` is low.
- R10: `phys_invalid` is high exactly when the selected block is enabled and the untruncated sum is 0x10000000 or more.
- R11: Changes take effect in the cycle after the map strobe edge. Without a map strobe, register inputs have no effect on the mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_stb | input | 1 | Map instruction executes this cycle |
| eom_stb | input | 1 | End-of-map instruction executes this cycle |
| hyper_mode | input | 1 | CPU is in hypervisor mode |
| reg_a | input | 8 | CPU register A |
| reg_x | input | 8 | CPU register X |
| reg_y | input | 8 | CPU register Y |
| reg_z | input | 8 | CPU register Z |
| cpu_addr | input | 16 | Logical address to translate |
| phys_addr | output | 28 | Translated physical address |
| phys_invalid | output | 1 | Mapped sum lies at or above 256 MB |
| blk_mapped | output | 1 | Selected block is relocated |
| irq_inhibit | output | 1 | Interrupts held off until end-of-map |
| hyper_warn | output | 1 | One-cycle pulse: upper megabyte changed in hypervisor mode |

## Verification
The bench builds the block with its default widths: a 16-bit logical address, a 28-bit physical space and 8-bit registers. These values let a megabyte selector of 0xFF, together with a large upper offset, push the sum past 0x10000000, so the impossible-address flag and the truncation can be reached. Register values chosen to be 0x0F and values close to it exercise both the megabyte path and the offset path of each half, with and without hypervisor protection.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
  localparam int LOG_W     = 16;
  localparam int PHYS_W    = 28;
  localparam int REG_W     = 8;
  localparam int BLK_SEL_W = 3;
  localparam int NUM_BLK   = 1 << BLK_SEL_W;
  localparam int HALF_BLK  = NUM_BLK / 2;
  localparam int NIB_W     = 4;
  localparam int PAGE_SH   = 8;
  localparam int OFS_W     = LOG_W + NIB_W;
  localparam int MB_SH     = OFS_W;
  localparam logic [REG_W-1:0] MB_CODE = 8'h0F;

  typedef struct packed {
    logic [OFS_W-1:0]   ofs_lo;
    logic [OFS_W-1:0]   ofs_hi;
    logic [REG_W-1:0]   mb_lo;
    logic [REG_W-1:0]   mb_hi;
    logic [NUM_BLK-1:0] en;
  } map_state_t;
endpackage

// File: rtl/mmap_state.sv
module mmap_state
  import mmap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             map_stb,
  input  logic             eom_stb,
  input  logic             hyper_mode,
  input  logic [REG_W-1:0] reg_a,
  input  logic [REG_W-1:0] reg_x,
  input  logic [REG_W-1:0] reg_y,
  input  logic [REG_W-1:0] reg_z,
  output map_state_t       st,
  output logic             irq_inhibit,
  output logic             hyper_warn
);
  map_state_t st_nx;
  logic       inh_nx;
  logic       warn_nx;
  logic       lo_mb_sel;
  logic       hi_mb_sel;

  assign lo_mb_sel = (reg_x == MB_CODE);
  assign hi_mb_sel = (reg_z == MB_CODE);

  always_comb begin
    st_nx = st;
    if (lo_mb_sel) begin
      st_nx.mb_lo = reg_a;
    end else begin
      st_nx.ofs_lo = {reg_x[NIB_W-1:0], reg_a, {PAGE_SH{1'b0}}};
      st_nx.en[HALF_BLK-1:0] = reg_x[REG_W-1 -: NIB_W];
    end
    if (hi_mb_sel) begin
      st_nx.mb_hi = reg_y;
    end else if (!hyper_mode) begin
      st_nx.ofs_hi = {reg_z[NIB_W-1:0], reg_y, {PAGE_SH{1'b0}}};
      st_nx.en[NUM_BLK-1:HALF_BLK] = reg_z[REG_W-1 -: NIB_W];
    end
  end

  always_comb begin
    warn_nx = map_stb && hi_mb_sel && hyper_mode;
    if (map_stb) begin
      inh_nx = 1'b1;
    end else if (eom_stb) begin
      inh_nx = 1'b0;
    end else begin
      inh_nx = irq_inhibit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
    end else if (map_stb) begin
      st <= st_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_inhibit <= 1'b0;
      hyper_warn  <= 1'b0;
    end else begin
      irq_inhibit <= inh_nx;
      hyper_warn  <= warn_nx;
    end
  end

  a_r5_hyper_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (map_stb && hyper_mode && (reg_z != MB_CODE)) |=>
      ($stable(st.ofs_hi) && $stable(st.en[NUM_BLK-1:HALF_BLK])));

  a_r3_mb_keeps_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (map_stb && (reg_x == MB_CODE)) |=>
      ($stable(st.ofs_lo) && $stable(st.en[HALF_BLK-1:0])));

  a_r6_warn_only_hyper: assert property (@(posedge clk) disable iff (!rst_n)
    (map_stb && !hyper_mode) |=> !hyper_warn);

  a_r7_inhibit_set: assert property (@(posedge clk) disable iff (!rst_n)
    map_stb |=> irq_inhibit);

  a_r7_inhibit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_inhibit && !eom_stb) |=> irq_inhibit);

  a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !map_stb |=> $stable(st));
endmodule

// File: rtl/mmap_xlate.sv
module mmap_xlate
  import mmap_pkg::*;
(
  input  map_state_t        st,
  input  logic [LOG_W-1:0]  cpu_addr,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              phys_invalid,
  output logic              blk_mapped
);
  localparam int SUM_W = PHYS_W + 1;

  logic [BLK_SEL_W-1:0] blk;
  logic                 upper;
  logic [OFS_W-1:0]     ofs_sel;
  logic [REG_W-1:0]     mb_sel;
  logic [SUM_W-1:0]     sum;
  logic [NUM_BLK-1:0]   blk_hit;

  assign blk   = cpu_addr[LOG_W-1 -: BLK_SEL_W];
  assign upper = blk[BLK_SEL_W-1];

  for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
    assign blk_hit[i] = (blk == BLK_SEL_W'(i)) && st.en[i];
  end

  always_comb begin
    ofs_sel    = upper ? st.ofs_hi : st.ofs_lo;
    mb_sel     = upper ? st.mb_hi  : st.mb_lo;
    blk_mapped = |blk_hit;
    sum = (SUM_W'(mb_sel) << MB_SH) + SUM_W'(ofs_sel) + SUM_W'(cpu_addr);
    if (blk_mapped) begin
      phys_addr    = sum[PHYS_W-1:0];
      phys_invalid = sum[PHYS_W];
    end else begin
      phys_addr    = PHYS_W'(cpu_addr);
      phys_invalid = 1'b0;
    end
  end
endmodule

// File: rtl/banked_mem_mapper.sv
module banked_mem_mapper
  import mmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_stb,
  input  logic              eom_stb,
  input  logic              hyper_mode,
  input  logic [REG_W-1:0]  reg_a,
  input  logic [REG_W-1:0]  reg_x,
  input  logic [REG_W-1:0]  reg_y,
  input  logic [REG_W-1:0]  reg_z,
  input  logic [LOG_W-1:0]  cpu_addr,
  output logic [PHYS_W-1:0] phys_addr,
  output logic              phys_invalid,
  output logic              blk_mapped,
  output logic              irq_inhibit,
  output logic              hyper_warn
);
  map_state_t st;

  mmap_state u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .map_stb    (map_stb),
    .eom_stb    (eom_stb),
    .hyper_mode (hyper_mode),
    .reg_a      (reg_a),
    .reg_x      (reg_x),
    .reg_y      (reg_y),
    .reg_z      (reg_z),
    .st         (st),
    .irq_inhibit(irq_inhibit),
    .hyper_warn (hyper_warn)
  );

  mmap_xlate u_xlate (
    .st          (st),
    .cpu_addr    (cpu_addr),
    .phys_addr   (phys_addr),
    .phys_invalid(phys_invalid),
    .blk_mapped  (blk_mapped)
  );

  a_r10_invalid_needs_map: assert property (@(posedge clk) disable iff (!rst_n)
    phys_invalid |-> blk_mapped);
endmodule

// File: tb/tb_banked_mem_mapper.sv
module tb_banked_mem_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_stb = 1'b0;
  logic        eom_stb = 1'b0;
  logic        hyper_mode = 1'b0;
  logic [7:0]  reg_a = '0, reg_x = '0, reg_y = '0, reg_z = '0;
  logic [15:0] cpu_addr = '0;
  logic [27:0] phys_addr;
  logic        phys_invalid, blk_mapped, irq_inhibit, hyper_warn;

  always #5 clk = ~clk;

  banked_mem_mapper dut (
    .clk(clk), .rst_n(rst_n), .map_stb(map_stb), .eom_stb(eom_stb),
    .hyper_mode(hyper_mode), .reg_a(reg_a), .reg_x(reg_x), .reg_y(reg_y),
    .reg_z(reg_z), .cpu_addr(cpu_addr), .phys_addr(phys_addr),
    .phys_invalid(phys_invalid), .blk_mapped(blk_mapped),
    .irq_inhibit(irq_inhibit), .hyper_warn(hyper_warn)
  );

  typedef struct {
    logic [27:0] phys;
    logic        inv;
    logic        mapd;
    logic        inh;
    logic        warn;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  // reference state
  logic [19:0] m_ofs_lo = '0, m_ofs_hi = '0;
  logic [7:0]  m_mb_lo = '0, m_mb_hi = '0, m_en = '0;
  logic        m_inh = 1'b0, m_warn = 1'b0;

  task automatic do_map(input logic [7:0] a, x, y, z, input logic hyp, input logic eom);
    @(posedge clk); #1;
    reg_a = a; reg_x = x; reg_y = y; reg_z = z;
    hyper_mode = hyp; map_stb = 1'b1; eom_stb = eom;
    @(posedge clk); #1;
    map_stb = 1'b0; eom_stb = 1'b0; hyper_mode = 1'b0;
    if (x == 8'h0F) m_mb_lo = a;
    else begin
      m_ofs_lo = (20'(a) << 8) | (20'(x & 8'h0F) << 16);
      m_en[3:0] = x[7:4];
    end
    if (z == 8'h0F) m_mb_hi = y;
    else if (!hyp) begin
      m_ofs_hi = (20'(y) << 8) | (20'(z & 8'h0F) << 16);
      m_en[7:4] = z[7:4];
    end
    m_inh  = 1'b1;
    m_warn = hyp && (z == 8'h0F);
  endtask

  task automatic do_eom();
    @(posedge clk); #1;
    eom_stb = 1'b1;
    @(posedge clk); #1;
    eom_stb = 1'b0;
    m_inh = 1'b0; m_warn = 1'b0;
  endtask

  task automatic check_addr(input logic [15:0] addr, input string tag);
    exp_t e;
    logic [28:0] s;
    logic        hi;
    hi = addr[15];
    s = (29'(hi ? m_mb_hi : m_mb_lo) << 20) + 29'(hi ? m_ofs_hi : m_ofs_lo) + 29'(addr);
    e.mapd = m_en[addr[15:13]];
    e.phys = e.mapd ? s[27:0] : {12'h000, addr};
    e.inv  = e.mapd && s[28];
    e.inh  = m_inh;
    e.warn = m_warn;
    e.tag  = tag;
    cpu_addr = addr;
    q.push_back(e);
    @(posedge clk); #1;
    m_warn = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (phys_addr !== e.phys || phys_invalid !== e.inv || blk_mapped !== e.mapd ||
            irq_inhibit !== e.inh || hyper_warn !== e.warn) begin
          errors++;
          $display("FAIL %s addr=%h actual phys=%h inv=%b map=%b inh=%b warn=%b expected phys=%h inv=%b map=%b inh=%b warn=%b",
                   e.tag, cpu_addr, phys_addr, phys_invalid, blk_mapped, irq_inhibit, hyper_warn,
                   e.phys, e.inv, e.mapd, e.inh, e.warn);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 / R9: reset state passes addresses through
    check_addr(16'h1234, "R1");
    check_addr(16'hFFFF, "R9");
    // R2 / R8: lower offset and blocks 0,1 enabled
    do_map(8'h80, 8'h31, 8'h00, 8'h00, 1'b0, 1'b0);
    check_addr(16'h0100, "R2");
    check_addr(16'h4000, "R9");
    // R7: end-of-map clears inhibit
    do_eom();
    check_addr(16'h2010, "R7");
    // R3 lower megabyte, R4 upper offset
    do_map(8'h05, 8'h0F, 8'h40, 8'hC2, 1'b0, 1'b0);
    check_addr(16'h0100, "R3");
    check_addr(16'hC000, "R4");
    check_addr(16'h8000, "R4");
    // R5: hypervisor blocks upper change
    do_map(8'h05, 8'h0F, 8'h77, 8'hF3, 1'b1, 1'b0);
    check_addr(16'hC000, "R5");
    check_addr(16'h8000, "R5");
    // R6: upper megabyte in hypervisor mode, warn pulse
    do_map(8'h05, 8'h0F, 8'hFF, 8'h0F, 1'b1, 1'b0);
    check_addr(16'hE000, "R6");
    check_addr(16'hFFFF, "R6");
    // R10: overflow past 256 MB
    do_map(8'h05, 8'h0F, 8'hFF, 8'hCF, 1'b0, 1'b0);
    check_addr(16'hE000, "R10");
    check_addr(16'hC000, "R10");
    // R6: no warn outside hypervisor mode
    do_map(8'h05, 8'h0F, 8'h01, 8'h0F, 1'b0, 1'b0);
    check_addr(16'hE000, "R6");
    // R2: upper enables kept on lower update
    do_map(8'h00, 8'h20, 8'h01, 8'h0F, 1'b0, 1'b0);
    check_addr(16'h2000, "R2");
    check_addr(16'hC000, "R2");
    // R7: simultaneous map and end-of-map keeps inhibit set
    do_map(8'h00, 8'h20, 8'h01, 8'h0F, 1'b0, 1'b1);
    check_addr(16'h2004, "R7");
    do_eom();
    check_addr(16'h2004, "R7");
    // R11: register inputs ignored without map strobe
    @(posedge clk); #1;
    reg_a = 8'hAA; reg_x = 8'hF5; reg_y = 8'h55; reg_z = 8'hF1; hyper_mode = 1'b0;
    @(posedge clk); #1;
    check_addr(16'h2000, "R11");
    check_addr(16'hC000, "R11");
    check_addr(16'h4000, "R11");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule